// File: doc/BRIEF.md
# QoS Priority Arbiter with Wait Aging

This block chooses one winner per cycle among a set of request ports that share a single downstream channel. Each port raises a request and presents a 4-bit service level with it. Level 0 is the least urgent and level 15 the most urgent. The port with the highest effective level wins. Ports that tie on the winning level take turns in round-robin order. Each level keeps its own rotation pointer, so grants at one level never disturb the turn order at another.

Starvation is prevented by a per-port wait counter and a per-port limit that software programs. Once a port has been waiting for at least its limit, its effective level is forced to 15 until it is served. A limit of zero turns this promotion off for that port. The grant is a registered one-hot pulse. A requester keeps its request high until it sees the grant, so the port shown as granted is left out of the following decision.

Top module: `qos_age_arbiter`

## Requirements
- R1: `gnt_o` is registered and has at most one bit set. A bit is set only if that port's request was high in the cycle before the grant appears.
- R2: Among eligible ports, the grant goes to a port with the largest effective level. An eligible port has its request high and is not currently shown as granted. Its effective level is its input level, or 15 when it has aged.
- R3: Eligible ports that tie on the winning level are served in rotation. The search starts at the port after the last one granted at that level, wrapping from the highest index to port 0.
- R4: Each level has its own rotation pointer. The pointer changes only when a grant is issued at that level.
- R5: A port whose grant bit is high is not eligible in that cycle, so no port is granted in two consecutive cycles.
- R6: A port's wait count clears when it wins or when its request is low. While the port is eligible and does not win, the count rises by one per cycle, saturating at all ones. While the port is shown as granted, the count holds.
- R7: When a port's limit is nonzero and its wait count is at least that limit, its effective level is 15. It then competes in the level-15 rotation, and `gnt_lvl_o` reports 15 when it wins.
- R8: A limit of zero disables promotion: the port always competes at its input level.
- R9: During reset `gnt_o` and `gnt_lvl_o` are zero. After reset every rotation pointer starts at port 0 and every wait count is zero.
- R10: `gnt_lvl_o` carries the effective level that won, registered alongside `gnt_o`. It is zero in a cycle with no grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_PORTS | Request per port, held until granted |
| prio_i | input | 4*NUM_PORTS | Service level per port, port i at bits [4i+3:4i] |
| tmo_i | input | TMO_W*NUM_PORTS | Wait limit per port, port i at bits [TMO_W*i+TMO_W-1:TMO_W*i]; zero disables promotion |
| gnt_o | output | NUM_PORTS | Registered one-hot grant |
| gnt_lvl_o | output | 4 | Effective level of the granted port |

## Verification
Two functions can act in the same cycle: a port's promotion to level 15, and the rotation among ports that already request at level 15. When both happen, the promoted port has to take its turn in the level-15 rotation instead of jumping ahead. A long stretch of random traffic provokes this case. In that traffic, native level-15 requests mix with short wait limits, and a cycle-by-cycle model built from the requirements predicts every grant and level. Directed sequences pin down the exact cycle of promotion, the restart of the wait count after a dropped request, and the independence of the per-level pointers.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;
  localparam int QOS_W   = 4;
  localparam int QOS_LVLS = 1 << QOS_W;
  typedef logic [QOS_W-1:0] qos_t;
  localparam qos_t QOS_TOP = qos_t'(QOS_LVLS - 1);
endpackage

// File: rtl/qos_wait_ager.sv
module qos_wait_ager
  import qos_arb_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             blocked,
  input  logic             won,
  input  logic [TMO_W-1:0] limit,
  input  qos_t             base_lvl,
  output qos_t             eff_lvl
);
  localparam logic [TMO_W-1:0] CNT_SAT = '1;

  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] cnt_d;
  logic             cnt_en;
  logic             aged;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (won || !req) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (!blocked && (cnt_q != CNT_SAT)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign aged    = (limit != '0) && (cnt_q >= limit);
  assign eff_lvl = aged ? QOS_TOP : base_lvl;
endmodule

// File: rtl/qos_level_max.sv
module qos_level_max
  import qos_arb_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0]       elig,
  input  logic [NUM_PORTS*QOS_W-1:0] lvl_flat,
  output qos_t                       top_lvl,
  output logic                       any_elig
);
  always_comb begin
    top_lvl  = '0;
    any_elig = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (elig[i]) begin
        any_elig = 1'b1;
        if (lvl_flat[i*QOS_W +: QOS_W] > top_lvl) begin
          top_lvl = lvl_flat[i*QOS_W +: QOS_W];
        end
      end
    end
  end
endmodule

// File: rtl/qos_rr_pick.sv
module qos_rr_pick #(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [NUM_PORTS-1:0] match,
  input  logic [IDX_W-1:0]     start,
  output logic [NUM_PORTS-1:0] win,
  output logic [IDX_W-1:0]     win_idx
);
  always_comb begin
    logic found;
    found   = 1'b0;
    win     = '0;
    win_idx = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      int j;
      j = (int'(start) + k) % NUM_PORTS;
      if (!found && match[j]) begin
        found   = 1'b1;
        win[j]  = 1'b1;
        win_idx = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/qos_ptr_bank.sv
module qos_ptr_bank
  import qos_arb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd_en,
  input  qos_t                      upd_lvl,
  input  logic [IDX_W-1:0]          upd_idx,
  output logic [QOS_LVLS*IDX_W-1:0] ptr_flat
);
  logic [IDX_W-1:0] next_idx;

  always_comb begin
    if (int'(upd_idx) == NUM_PORTS - 1) next_idx = '0;
    else                                next_idx = upd_idx + 1'b1;
  end

  for (genvar g = 0; g < QOS_LVLS; g++) begin : g_lvl
    logic [IDX_W-1:0] ptr_q;
    logic             ptr_en;

    assign ptr_en = upd_en && (upd_lvl == qos_t'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q <= '0;
      end else if (ptr_en) begin
        ptr_q <= next_idx;
      end
    end

    assign ptr_flat[g*IDX_W +: IDX_W] = ptr_q;
  end
endmodule

// File: rtl/qos_age_arbiter.sv
module qos_age_arbiter
  import qos_arb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int TMO_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS-1:0]       req_i,
  input  logic [NUM_PORTS*4-1:0]     prio_i,
  input  logic [NUM_PORTS*TMO_W-1:0] tmo_i,
  output logic [NUM_PORTS-1:0]       gnt_o,
  output logic [3:0]                 gnt_lvl_o
);
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [NUM_PORTS-1:0]       gnt_q;
  logic [NUM_PORTS-1:0]       gnt_d;
  qos_t                       lvl_q;
  qos_t                       lvl_d;
  logic [NUM_PORTS-1:0]       elig;
  logic [NUM_PORTS-1:0]       match;
  logic [NUM_PORTS-1:0]       win;
  logic [NUM_PORTS*QOS_W-1:0] eff_flat;
  qos_t                       top_lvl;
  logic                       any_elig;
  logic [QOS_LVLS*IDX_W-1:0]  ptr_flat;
  logic [IDX_W-1:0]           sel_ptr;
  logic [IDX_W-1:0]           win_idx;

  assign elig = req_i & ~gnt_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    qos_t eff;

    qos_wait_ager #(.TMO_W(TMO_W)) u_ager (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_i[p]),
      .blocked  (gnt_q[p]),
      .won      (win[p]),
      .limit    (tmo_i[p*TMO_W +: TMO_W]),
      .base_lvl (prio_i[p*QOS_W +: QOS_W]),
      .eff_lvl  (eff)
    );

    assign eff_flat[p*QOS_W +: QOS_W] = eff;
    assign match[p] = elig[p] && (eff == top_lvl);
  end

  qos_level_max #(.NUM_PORTS(NUM_PORTS)) u_max (
    .elig     (elig),
    .lvl_flat (eff_flat),
    .top_lvl  (top_lvl),
    .any_elig (any_elig)
  );

  assign sel_ptr = ptr_flat[top_lvl*IDX_W +: IDX_W];

  qos_rr_pick #(.NUM_PORTS(NUM_PORTS)) u_pick (
    .match   (match),
    .start   (sel_ptr),
    .win     (win),
    .win_idx (win_idx)
  );

  qos_ptr_bank #(.NUM_PORTS(NUM_PORTS)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (any_elig),
    .upd_lvl  (top_lvl),
    .upd_idx  (win_idx),
    .ptr_flat (ptr_flat)
  );

  always_comb begin
    gnt_d = win;
    lvl_d = any_elig ? top_lvl : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
      lvl_q <= '0;
    end else begin
      gnt_q <= gnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign gnt_o     = gnt_q;
  assign gnt_lvl_o = lvl_q;
endmodule

// File: rtl/qos_age_arbiter_chk.sv
module qos_age_arbiter_chk #(
  parameter int NUM_PORTS = 4,
  parameter int TMO_W     = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_PORTS-1:0]       req_i,
  input logic [NUM_PORTS*4-1:0]     prio_i,
  input logic [NUM_PORTS*TMO_W-1:0] tmo_i,
  input logic [NUM_PORTS-1:0]       gnt_o,
  input logic [3:0]                 gnt_lvl_o
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assert_onehot_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  assert_no_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (gnt_o & $past(gnt_o)) == '0);

  assert_idle_level_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == '0) |-> (gnt_lvl_o == 4'd0));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    assert_grant_had_req_R1: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      gnt_o[p] |-> $past(req_i[p]));

    assert_top_level_wins_R2: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      $past(req_i[p] && !gnt_o[p]) |->
        ((gnt_o != '0) && (gnt_lvl_o >= $past(prio_i[p*4 +: 4]))));
  end
endmodule

bind qos_age_arbiter qos_age_arbiter_chk #(
  .NUM_PORTS (NUM_PORTS),
  .TMO_W     (TMO_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .prio_i    (prio_i),
  .tmo_i     (tmo_i),
  .gnt_o     (gnt_o),
  .gnt_lvl_o (gnt_lvl_o)
);

// File: tb/test_qos_age_arbiter.sv
module test_qos_age_arbiter;
  localparam int N      = 4;
  localparam int TW     = 4;
  localparam int CLK_PER = 10;
  localparam int CMAX   = (1 << TW) - 1;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    req;
  logic [N*4-1:0]  prio;
  logic [N*TW-1:0] tmo;
  logic [N-1:0]    gnt;
  logic [3:0]      lvl;

  int n_chk;
  int n_bad;
  bit done;

  int         ptr_m [16];
  int         cnt_m [N];
  logic [N-1:0] gq_m;
  logic [N-1:0] exp_g;
  logic [3:0]   exp_l;

  qos_age_arbiter #(.NUM_PORTS(N), .TMO_W(TW)) i_qos_age_arbiter (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req),
    .prio_i    (prio),
    .tmo_i     (tmo),
    .gnt_o     (gnt),
    .gnt_lvl_o (lvl)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pv(input int i);
    return int'(prio[i*4 +: 4]);
  endfunction

  function automatic int tv(input int i);
    return int'(tmo[i*TW +: TW]);
  endfunction

  task automatic model_clear();
    for (int l = 0; l < 16; l++) ptr_m[l] = 0;
    for (int i = 0; i < N; i++) cnt_m[i] = 0;
    gq_m = '0;
  endtask

  task automatic model_step();
    int eff [N];
    int mx;
    int w;
    mx = -1;
    w  = -1;
    for (int i = 0; i < N; i++) begin
      eff[i] = (tv(i) != 0 && cnt_m[i] >= tv(i)) ? 15 : pv(i);
      if (req[i] && !gq_m[i] && eff[i] > mx) mx = eff[i];
    end
    if (mx >= 0) begin
      for (int k = 0; k < N; k++) begin
        int j;
        j = (ptr_m[mx] + k) % N;
        if (w < 0 && req[j] && !gq_m[j] && eff[j] == mx) w = j;
      end
    end
    exp_g = '0;
    exp_l = '0;
    if (w >= 0) begin
      exp_g[w] = 1'b1;
      exp_l = 4'(mx);
      ptr_m[mx] = (w + 1) % N;
    end
    for (int i = 0; i < N; i++) begin
      if (i == w || !req[i]) cnt_m[i] = 0;
      else if (!gq_m[i] && cnt_m[i] < CMAX) cnt_m[i]++;
    end
    gq_m = exp_g;
  endtask

  // one cycle: model predicts, design registers at posedge, compare at negedge
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(gnt == exp_g, "R2/R3/R4 grant", int'(gnt), int'(exp_g));
    check(lvl == exp_l, "R10/R7 level", int'(lvl), int'(exp_l));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req   = '0;
    model_clear();
    repeat (3) @(negedge clk);
    check(gnt == '0, "R9 reset grant", int'(gnt), 0);
    check(lvl == '0, "R9 reset level", int'(lvl), 0);
    rst_n = 1'b1;
  endtask

  function automatic int gidx();
    for (int i = 0; i < N; i++) if (gnt[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 0;
    rst_n = 1'b0;
    req   = '0;
    prio  = '0;
    tmo   = '0;
    @(negedge clk);

    // R3 / R9: equal levels rotate from port 0
    prio = {4'd7, 4'd7, 4'd7, 4'd7};
    tmo  = '0;
    do_reset();
    req = '1;
    for (int c = 0; c < 8; c++) begin
      tick();
      check(gidx() == c % N, "R3 rotation order", gidx(), c % N);
    end

    // R5: lone requester is skipped while shown granted
    do_reset();
    req  = 4'b0100;
    prio = {4'd0, 4'd3, 4'd0, 4'd0};
    for (int c = 0; c < 6; c++) begin
      tick();
      check(gidx() == ((c % 2 == 0) ? 2 : -1), "R5 held request masked", gidx(),
            (c % 2 == 0) ? 2 : -1);
    end

    // R7: port 3 level 0, limit 5, against two level-9 ports
    do_reset();
    prio = {4'd0, 4'd0, 4'd9, 4'd9};
    tmo  = {4'd5, 4'd0, 4'd0, 4'd0};
    req  = 4'b1011;
    for (int c = 1; c <= 6; c++) begin
      tick();
      check(gnt[3] == (c == 6), "R7 promotion cycle", int'(gnt[3]), int'(c == 6));
      if (c == 6) check(lvl == 4'd15, "R7 promoted level", int'(lvl), 15);
    end

    // R6: dropping the request restarts the wait count
    do_reset();
    req = 4'b1011;
    for (int c = 0; c < 3; c++) tick();
    req = 4'b0011;
    tick();
    req = 4'b1011;
    for (int c = 1; c <= 6; c++) begin
      tick();
      check(gnt[3] == (c == 6), "R6 count restart", int'(gnt[3]), int'(c == 6));
    end

    // R8: zero limit never promotes
    do_reset();
    tmo = '0;
    req = 4'b1011;
    for (int c = 0; c < 40; c++) begin
      tick();
      check(gnt[3] == 1'b0, "R8 aging disabled", int'(gnt[3]), 0);
    end

    // R4: a grant at level 12 leaves the level-5 pointer alone
    do_reset();
    prio = {4'd5, 4'd5, 4'd5, 4'd5};
    req  = '1;
    tick();
    check(gidx() == 0, "R4 first level-5 grant", gidx(), 0);
    prio = {4'd12, 4'd5, 4'd5, 4'd5};
    req  = 4'b1000;
    tick();
    check(gidx() == 3, "R4 level-12 grant", gidx(), 3);
    prio = {4'd5, 4'd5, 4'd5, 4'd5};
    req  = '1;
    tick();
    check(gidx() == 1, "R4 level-5 pointer kept", gidx(), 1);

    // mixed traffic: short limits, native level 15, promotion collisions
    do_reset();
    for (int c = 0; c < 6000; c++) begin
      if (c % 200 == 0) begin
        for (int i = 0; i < N; i++) tmo[i*TW +: TW] = TW'($urandom_range(0, 6));
      end
      for (int i = 0; i < N; i++) begin
        if (gnt[i] || ($urandom_range(0, 9) == 0)) req[i] = ($urandom_range(0, 3) != 0);
        if ($urandom_range(0, 7) == 0) prio[i*4 +: 4] = 4'($urandom_range(0, 15));
      end
      tick();
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule